// File: doc/BRIEF.md
# Echoed-Clock Command Frame Receiver

This block is the console-side end of a parallel link driven by a host. The host drives an 8-line bus. Bit 0 of that bus is a clock and bits 7..1 carry data. The block answers on a 5-line bus. Bit 0 of the answer bus returns the host clock and bits 4..1 carry a reply nibble. Each host clock period is one transfer. Data is taken when the host clock falls from 1 to 0, and every transfer carries a value in both directions.

A command frame has four transfers, all taken on falling edges:

1. The host leaves idle by sending all zeros, and the block answers with zeros.
2. The host sends a 7-bit command field.
3. The host sends the bitwise inverse of that field.
4. The host sends an acknowledge transfer. During it the block shows 0101 on its reply bits if the two copies agree and the code is legal. Otherwise it shows 1111.

At the falling edge of the acknowledge transfer, an accepted command is handed to later logic as a one-cycle strobe with the command field. The block then goes back to idle.

The host lines are asynchronous to the block clock. They pass through a synchronizer before any decision is made. A synchronous active-high reset puts the block back in idle from any point in a frame.

Top module: `echo_cmd_rx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, dev_bus is 5'b11111, link_idle is 1 and cmd_valid is 0.
- R2: dev_bus[0] follows host_bus[0] three clock cycles later: two synchronizer stages and one output register. Host data is acted on only at a falling edge of the synchronized host clock.
- R3: In idle, a falling edge with nonzero host data bits 7..1 is ignored. link_idle stays 1 and dev_bus[4:1] stays 4'b1111.
- R4: In idle, a falling edge with host data bits 7..1 all zero ends idle: link_idle goes to 0 and dev_bus[4:1] becomes 4'b0000.
- R5: The next falling edge captures host bits 7..1 as the command field, and dev_bus[4:1] becomes 4'b1111.
- R6: The next falling edge captures the inverse copy. If it equals the bitwise NOT of the command field and the field is legal, dev_bus[4:1] becomes 4'b0101 (pass). Otherwise it becomes 4'b1111 (fail).
- R7: A command field is legal only when it is 7'h00 to 7'h17 inclusive. These are the even byte codes 0x00 to 0x2E, with the clock bit as the byte's LSB. A larger field fails the check in R6.
- R8: The next falling edge after a pass raises cmd_valid for exactly one cycle, with cmd holding the captured field. On that same cycle link_idle returns to 1 and dev_bus[4:1] to 4'b1111.
- R9: After a fail, the acknowledge falling edge returns the block to idle with dev_bus[4:1] = 4'b1111, and cmd_valid stays 0.
- R10: Asserting rst in the middle of a frame returns the block to idle with dev_bus = 5'b11111. No command is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_bus | input | 8 | Host lines: bit 0 clock, bits 7..1 data (asynchronous) |
| dev_bus | output | 5 | Return lines: bit 0 echoed clock, bits 4..1 reply nibble |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd | output | 7 | Accepted command field (byte code divided by two) |
| link_idle | output | 1 | High while no frame is in progress |

## Verification
The bench sends frames with the edge codes 0x00 and 0x2E and the first illegal field 7'h18. A design with an off-by-one range check would accept the illegal field or reject an edge code, and a stray or missing strobe would show up in the scoreboard. The bench sends an inverse copy with one wrong bit. A design that compares without inverting, or that ignores the comparison, would reply 0101 and issue a command. Nonzero data is sent on a falling edge during idle. A design that starts a frame on any falling edge would drop link_idle. A reset is applied halfway through a frame. A design whose frame state survives reset would leave link_idle low or drive zeros on the reply bits.

// File: rtl/echo_link_pkg.sv
package echo_link_pkg;

    localparam int HOST_W     = 8;
    localparam int DEV_W      = 5;
    localparam int FIELD_W    = HOST_W - 1;
    localparam int NIB_W      = DEV_W - 1;
    localparam logic [FIELD_W-1:0] FIELD_MAX = 7'h17;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_CMD  = 2'd1,
        FR_INV  = 2'd2,
        FR_ACK  = 2'd3
    } frame_st_e;

    typedef enum logic [1:0] {
        RP_ONES = 2'd0,
        RP_ZERO = 2'd1,
        RP_PASS = 2'd2
    } reply_e;

    typedef struct packed {
        logic               fall;
        logic               clk_lvl;
        logic [FIELD_W-1:0] data;
    } host_sample_t;

    function automatic logic [NIB_W-1:0] reply_bits(input reply_e k);
        case (k)
            RP_ZERO: reply_bits = 4'b0000;
            RP_PASS: reply_bits = 4'b0101;
            default: reply_bits = 4'b1111;
        endcase
    endfunction

    function automatic logic field_legal(input logic [FIELD_W-1:0] f);
        field_legal = (f <= FIELD_MAX);
    endfunction

endpackage

// File: rtl/link_sync.sv
module link_sync
    import echo_link_pkg::*;
#(
    parameter int W      = HOST_W,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output host_sample_t smp
);
    logic [W-1:0] chain [STAGES];
    logic         clk_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '1;
                else if (g == 0) chain[g] <= raw;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) clk_prev <= 1'b1;
        else     clk_prev <= chain[STAGES-1][0];
    end

    always_comb begin
        smp.clk_lvl = chain[STAGES-1][0];
        smp.data    = chain[STAGES-1][W-1:1];
        smp.fall    = clk_prev & ~chain[STAGES-1][0];
    end

    p_fall_edge_r2: assert property (@(posedge clk) disable iff (rst)
        smp.fall |=> !smp.fall);
endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
    import echo_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  host_sample_t       smp,
    output reply_e             reply_sel,
    output logic               cmd_valid,
    output logic [FIELD_W-1:0] cmd,
    output logic               link_idle
);
    frame_st_e          st;
    logic [FIELD_W-1:0] cmd_q;
    logic               pass_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= FR_IDLE;
            cmd_q     <= '0;
            pass_q    <= 1'b0;
            cmd_valid <= 1'b0;
            reply_sel <= RP_ONES;
        end else begin
            cmd_valid <= 1'b0;
            if (smp.fall) begin
                case (st)
                    FR_IDLE: if (smp.data == '0) begin
                        st        <= FR_CMD;
                        reply_sel <= RP_ZERO;
                    end
                    FR_CMD: begin
                        cmd_q     <= smp.data;
                        st        <= FR_INV;
                        reply_sel <= RP_ONES;
                    end
                    FR_INV: begin
                        pass_q    <= (smp.data == ~cmd_q) && field_legal(cmd_q);
                        reply_sel <= ((smp.data == ~cmd_q) && field_legal(cmd_q))
                                     ? RP_PASS : RP_ONES;
                        st        <= FR_ACK;
                    end
                    default: begin
                        cmd_valid <= pass_q;
                        st        <= FR_IDLE;
                        reply_sel <= RP_ONES;
                    end
                endcase
            end
        end
    end

    assign cmd       = cmd_q;
    assign link_idle = (st == FR_IDLE);

    p_pulse_one_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);
    p_pulse_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(smp.fall) && link_idle);
    p_range_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd <= FIELD_MAX);
    p_hold_no_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !smp.fall |=> $stable(st));
endmodule

// File: rtl/reply_drv.sv
module reply_drv
    import echo_link_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_lvl,
    input  reply_e           reply_sel,
    output logic [DEV_W-1:0] dev_bus
);
    logic echo_q;

    always_ff @(posedge clk) begin
        if (rst) echo_q <= 1'b1;
        else     echo_q <= clk_lvl;
    end

    assign dev_bus = {reply_bits(reply_sel), echo_q};
endmodule

// File: rtl/echo_cmd_rx.sv
module echo_cmd_rx
    import echo_link_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [HOST_W-1:0]   host_bus,
    output logic [DEV_W-1:0]    dev_bus,
    output logic                cmd_valid,
    output logic [FIELD_W-1:0]  cmd,
    output logic                link_idle
);
    host_sample_t smp;
    reply_e       reply_sel;

    link_sync #(.W(HOST_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(host_bus), .smp(smp)
    );

    frame_fsm u_fsm (
        .clk(clk), .rst(rst), .smp(smp), .reply_sel(reply_sel),
        .cmd_valid(cmd_valid), .cmd(cmd), .link_idle(link_idle)
    );

    reply_drv u_drv (
        .clk(clk), .rst(rst), .clk_lvl(smp.clk_lvl),
        .reply_sel(reply_sel), .dev_bus(dev_bus)
    );

    p_idle_ones_r3: assert property (@(posedge clk) disable iff (rst)
        link_idle |-> dev_bus[DEV_W-1:1] == 4'b1111);
    p_start_zero_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(link_idle) |-> dev_bus[DEV_W-1:1] == 4'b0000);
    p_echo_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> dev_bus[0] == $past(smp.clk_lvl));
endmodule

// File: tb/echo_cmd_rx_bench.sv
module echo_cmd_rx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_bus = 8'hFF;
    logic [4:0] dev_bus;
    logic       cmd_valid;
    logic [6:0] cmd;
    logic       link_idle;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 1'b0;
    logic [6:0] exp_q [$];

    always #10 clk = ~clk;

    echo_cmd_rx u_echo_cmd_rx (
        .clk(clk), .rst(rst), .host_bus(host_bus), .dev_bus(dev_bus),
        .cmd_valid(cmd_valid), .cmd(cmd), .link_idle(link_idle)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            pulses++;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R9 unexpected strobe actual=%h expected=none", cmd);
            end else begin
                logic [6:0] e;
                e = exp_q.pop_front();
                if (cmd !== e) begin
                    failures++;
                    $display("FAIL R8 cmd actual=%h expected=%h", cmd, e);
                end
            end
        end
    end

    task automatic phase(input logic [6:0] d, input logic c);
        @(negedge clk);
        host_bus = {d, c};
        repeat (8) @(negedge clk);
    endtask

    task automatic frame(input logic [6:0] f, input logic [6:0] inv, input bit pass);
        phase(7'h7F, 1'b1);
        phase(7'h00, 1'b0);
        chk(dev_bus == 5'b00000 && !link_idle, "R4 start reply", {3'b0, dev_bus}, 8'h00);
        phase(f, 1'b1);
        chk(dev_bus == 5'b00001, "R2 echo high", {3'b0, dev_bus}, 8'h01);
        phase(f, 1'b0);
        chk(dev_bus == 5'b11110, "R5 capture reply", {3'b0, dev_bus}, 8'h1E);
        phase(inv, 1'b1);
        phase(inv, 1'b0);
        chk(dev_bus[4:1] == (pass ? 4'b0101 : 4'b1111), pass ? "R6 pass nibble" : "R7 fail nibble",
            {4'b0, dev_bus[4:1]}, pass ? 8'h05 : 8'h0F);
        phase(7'h55, 1'b1);
        if (pass) exp_q.push_back(f);
        phase(7'h55, 1'b0);
        chk(link_idle && dev_bus == 5'b11110, pass ? "R8 back to idle" : "R9 back to idle",
            {link_idle, 2'b0, dev_bus}, 8'h9E);
        phase(7'h7F, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(dev_bus == 5'b11111 && link_idle && !cmd_valid, "R1 reset", {link_idle, 2'b0, dev_bus}, 8'h9F);
        rst = 1'b0;
        @(negedge clk);
        chk(dev_bus == 5'b11111 && link_idle && !cmd_valid, "R1 after reset", {link_idle, 2'b0, dev_bus}, 8'h9F);

        // R3: idle ignores nonzero fall
        phase(7'h7F, 1'b1);
        phase(7'h2A, 1'b0);
        chk(link_idle && dev_bus == 5'b11110, "R3 idle ignore", {link_idle, 2'b0, dev_bus}, 8'h9E);
        phase(7'h7F, 1'b1);
        chk(dev_bus == 5'b11111, "R2 echo returns high", {3'b0, dev_bus}, 8'h1F);

        // R2: echo latency three cycles
        @(negedge clk);
        host_bus = 8'hFE;
        repeat (2) @(negedge clk);
        chk(dev_bus[0] == 1'b1, "R2 echo not early", {7'b0, dev_bus[0]}, 8'h01);
        @(negedge clk);
        chk(dev_bus[0] == 1'b0, "R2 echo at three", {7'b0, dev_bus[0]}, 8'h00);
        phase(7'h7F, 1'b1);

        frame(7'h08, ~7'h08, 1'b1);          // R8 typical code 0x10
        frame(7'h01, ~7'h01, 1'b1);          // reset-type code 0x02
        frame(7'h00, 7'h7F, 1'b1);           // R7 lowest code
        frame(7'h17, ~7'h17, 1'b1);          // R7 highest code 0x2E
        frame(7'h18, ~7'h18, 1'b0);          // R7 first illegal
        frame(7'h0A, ~7'h0A ^ 7'h04, 1'b0);  // R6 bad inverse
        frame(7'h0A, 7'h0A, 1'b0);           // R6 uninverted copy

        // R10: reset mid-frame
        phase(7'h00, 1'b0);
        phase(7'h05, 1'b1);
        phase(7'h05, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        host_bus = 8'hFF;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(link_idle && dev_bus == 5'b11111, "R10 mid-frame reset", {link_idle, 2'b0, dev_bus}, 8'h9F);
        frame(7'h05, ~7'h05, 1'b1);          // R10 clean after reset

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0 && pulses == 5, "R8 strobe count", pulses[7:0], 8'd5);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule